// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Arbiter with Locking and a Default Owner

This arbiter chooses which of several initiators drives a shared address/control bus. Every initiator presents a request and a lock line. The arbiter answers with a one-hot grant vector, a 4-bit owner number and a locked-transfer flag. It watches the transfer type, the burst code and the ready line of the bus. From these it hands the bus over only where a fixed-length burst ends. It can also cut a burst short when the owner has held the bus too long and someone else is waiting. It keeps a locked sequence together and parks the bus on a designated master when nobody is asking. One initiator is the default owner, which issues only idle transfers. Its request and lock lines are ignored, and it takes the bus whenever no other initiator can use it.

Two pulse inputs track initiators that have had a transfer split. A set pulse marks an initiator as waiting, and a clear pulse releases it. A waiting initiator drops out of arbitration. If it owns the bus, it loses the bus at the next ready cycle. Arbitration is fixed priority: among the eligible initiators, the lowest index wins.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted, the owner number equals DEFAULT_ID, the grant vector has only bit DEFAULT_ID set, and the lock flag is 0.
- R2: On a clock edge where `hready` is low, the grant vector, owner number and lock flag do not change, and the burst and tenure tracking do not advance.
- R3: On a ready cycle that is a burst boundary, the owner becomes the lowest-indexed eligible initiator. An eligible initiator is one that requests, is not split-waiting and is not the default owner. A burst boundary is a ready cycle whose transfer leaves no beats outstanding: an IDLE (`htrans`=00) cycle, a NONSEQ (10) cycle with SINGLE (000) or INCR (001) burst code, or the last SEQ (11) beat of a fixed burst.
- R4: While beats of a fixed burst remain, the grant stays put. The length comes from the burst code: 4 beats for 010/011, 8 for 100/101, 16 for 110/111. BUSY (01) cycles consume no beat.
- R5: If EARLY_END is set, the owner has completed MAX_BEATS accepted beats since it gained the bus, and another initiator is eligible, then the grant moves mid-burst to the lowest-indexed eligible initiator other than the owner. The tenure count saturates and does not restart while the same owner keeps winning.
- R6: While the owner drives its lock line high, no other initiator is granted.
- R7: After the owner's lock line falls, the owner keeps the grant for one further ready cycle.
- R8: At each ready edge, the lock flag takes the lock line of the initiator granted at that edge. It is always 0 for the default owner.
- R9: A `splitSet` pulse marks an initiator as waiting from the next cycle. A `splitClear` pulse releases it, and clear wins if both arrive together. A waiting owner loses the grant at the next ready edge, even mid-burst or locked.
- R10: When no initiator is eligible but at least one non-default initiator is requesting, all such initiators are split-waiting, and the default owner is granted.
- R11: When no non-default initiator is requesting, the bus is parked on PARK_ID, or on DEFAULT_ID if PARK_ID is split-waiting.
- R12: The grant vector is always one-hot, and its set bit is the owner number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | NUM_MASTERS | Bus request, one bit per initiator |
| lockIn | input | NUM_MASTERS | Locked-sequence request, one bit per initiator |
| htrans | input | 2 | Transfer type of the current address phase |
| hburst | input | 3 | Burst code of the current address phase |
| hready | input | 1 | Bus ready; arbitration state moves only when high |
| splitSet | input | NUM_MASTERS | Pulse: initiator is now waiting on a split |
| splitClear | input | NUM_MASTERS | Pulse: initiator's split has completed |
| grantOut | output | NUM_MASTERS | One-hot grant |
| masterId | output | ID_W | Number of the granted initiator |
| masterLock | output | 1 | Current transfer belongs to a locked sequence |

## Verification
On every cycle, assertions check that the grant vector matches the owner number, and that a low `hready` freezes the grant and lock flag. They also check that a held lock or a pending lock tail keeps the owner in place, and that an all-split request pattern lands on the default owner. Only the bench's scenarios show the sequences that unfold over many cycles. These are a four-beat burst paused by a wait state and handed over on its last beat, and an eight-beat burst with a BUSY cycle cut after its fourth beat. They also include tenure saturating while a lone owner bursts on, split eviction and release ordering, and parking.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic update;   // ready cycle: registers may load
    logic rearb;    // full re-arbitration allowed this edge
    logic cutEarly; // forced hand-over to another initiator
  } arbStb_t;

  localparam int REM_W = 5;

  // Beats in a fixed-length burst; 1 for single and open-ended codes
  function automatic logic [REM_W-1:0] burstBeats(input logic [2:0] code);
    logic [REM_W-1:0] beats;
    unique case (code[2:1])
      2'b01:   beats = REM_W'(4);
      2'b10:   beats = REM_W'(8);
      2'b11:   beats = REM_W'(16);
      default: beats = REM_W'(1);
    endcase
    return beats;
  endfunction

endpackage

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
  import busarb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int DEFAULT_ID  = 0,
  parameter int MAX_BEATS   = 8,
  parameter bit EARLY_END   = 1'b1,
  parameter int ID_W        = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] lockIn,
  input  logic [1:0]             htrans,
  input  logic [2:0]             hburst,
  input  logic                   hready,
  input  logic [NUM_MASTERS-1:0] splitSet,
  input  logic [NUM_MASTERS-1:0] splitClear,
  input  logic [NUM_MASTERS-1:0] grantVec,
  input  logic [ID_W-1:0]        ownerId,
  output arbStb_t                stb,
  output logic [NUM_MASTERS-1:0] eligible,
  output logic                   reqNonDef,
  output logic [NUM_MASTERS-1:0] pendMask
);

  localparam int TEN_W = $clog2(MAX_BEATS + 1);
  localparam logic [NUM_MASTERS-1:0] DEF_MASK = NUM_MASTERS'(1) << DEFAULT_ID;
  localparam logic [TEN_W-1:0] TEN_MAX = TEN_W'(MAX_BEATS);

  logic [NUM_MASTERS-1:0] pendQ;
  logic [REM_W-1:0]       remQ, remEff, remNext;
  logic [TEN_W-1:0]       tenQ, tenEff, tenNext;
  logic [ID_W-1:0]        tenOwner;
  logic                   tailQ;
  logic                   sameOwner, accepted, boundary;
  logic                   ownLock, ownPend, lockHold, otherElig;
  trans_e                 trans;

  assign trans = trans_e'(htrans);

  // Split-waiting flags; the default owner is never tracked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ | splitSet) & ~splitClear & ~DEF_MASK;
  end

  assign pendMask  = pendQ;
  assign eligible  = reqIn & ~pendQ & ~DEF_MASK;
  assign reqNonDef = |(reqIn & ~DEF_MASK);

  // Burst/tenure tracking restarts whenever the owner changes
  assign sameOwner = (ownerId == tenOwner);
  assign remEff    = sameOwner ? remQ : '0;
  assign tenEff    = sameOwner ? tenQ : '0;
  assign accepted  = hready && (trans == TR_NONSEQ || trans == TR_SEQ);

  always_comb begin
    unique case (trans)
      TR_NONSEQ: remNext = burstBeats(hburst) - REM_W'(1);
      TR_SEQ:    remNext = (remEff != '0) ? remEff - REM_W'(1) : '0;
      TR_BUSY:   remNext = remEff;
      default:   remNext = '0;
    endcase
  end

  always_comb begin
    tenNext = tenEff;
    if (accepted && tenEff < TEN_MAX) tenNext = tenEff + TEN_W'(1);
  end

  assign boundary  = (remNext == '0);
  assign ownLock   = |(lockIn & grantVec & ~DEF_MASK);
  assign ownPend   = |(pendQ & grantVec);
  assign lockHold  = ownLock || tailQ;
  assign otherElig = |(eligible & ~grantVec);

  always_comb begin
    stb          = '0;
    stb.update   = hready;
    stb.rearb    = hready && (ownPend || (boundary && !lockHold));
    stb.cutEarly = hready && EARLY_END && !ownPend && !lockHold && !boundary
                   && (tenNext >= TEN_MAX) && otherElig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ     <= '0;
      tenQ     <= '0;
      tenOwner <= ID_W'(DEFAULT_ID);
      tailQ    <= 1'b0;
    end else if (hready) begin
      remQ     <= remNext;
      tenQ     <= tenNext;
      tenOwner <= ownerId;
      tailQ    <= ownLock && !ownPend;
    end
  end

  AST_LOCK_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (hready && ownLock && !ownPend) |=> $stable(grantVec)); // R6

  AST_LOCK_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hready && tailQ && !ownLock && !ownPend) |=> $stable(ownerId)); // R7

endmodule

// File: rtl/busarb_path.sv
module busarb_path
  import busarb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int DEFAULT_ID  = 0,
  parameter int PARK_ID     = 0,
  parameter int ID_W        = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arbStb_t                stb,
  input  logic [NUM_MASTERS-1:0] eligible,
  input  logic                   reqNonDef,
  input  logic [NUM_MASTERS-1:0] pendMask,
  input  logic [NUM_MASTERS-1:0] lockIn,
  output logic [NUM_MASTERS-1:0] grantOut,
  output logic [ID_W-1:0]        masterId,
  output logic                   masterLock
);

  localparam logic [NUM_MASTERS-1:0] DEF_MASK = NUM_MASTERS'(1) << DEFAULT_ID;

  logic [NUM_MASTERS-1:0] grantQ, nextGrant, otherSet;
  logic [ID_W-1:0]        idQ, nextId, pickAll, pickOther, fallbackId;
  logic                   lockQ;

  function automatic logic [ID_W-1:0] lowestIdx(input logic [NUM_MASTERS-1:0] v);
    logic [ID_W-1:0] r;
    r = ID_W'(DEFAULT_ID);
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction

  assign otherSet   = eligible & ~grantQ;
  assign pickAll    = lowestIdx(eligible);
  assign pickOther  = lowestIdx(otherSet);
  assign fallbackId = (reqNonDef || pendMask[PARK_ID]) ? ID_W'(DEFAULT_ID) : ID_W'(PARK_ID);

  always_comb begin
    nextId = idQ;
    if (stb.update && stb.rearb)         nextId = (|eligible) ? pickAll : fallbackId;
    else if (stb.update && stb.cutEarly) nextId = pickOther;
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_decode
    assign nextGrant[g] = (nextId == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ    <= ID_W'(DEFAULT_ID);
      grantQ <= DEF_MASK;
      lockQ  <= 1'b0;
    end else if (stb.update) begin
      idQ    <= nextId;
      grantQ <= nextGrant;
      lockQ  <= |(lockIn & nextGrant & ~DEF_MASK);
    end
  end

  assign grantOut   = grantQ;
  assign masterId   = idQ;
  assign masterLock = lockQ;

  AST_GRANT_MATCHES_ID: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(grantOut) && grantOut[masterId]); // R12

  AST_NOT_READY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.update |=> $stable(masterId) && $stable(grantOut) && $stable(masterLock)); // R2

  AST_ALLSPLIT_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.update && stb.rearb && eligible == '0 && reqNonDef)
      |=> masterId == ID_W'(DEFAULT_ID)); // R10

  AST_DEFAULT_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (masterId == ID_W'(DEFAULT_ID)) |-> !masterLock); // R8

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import busarb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int DEFAULT_ID  = 0,
  parameter int PARK_ID     = 0,
  parameter int MAX_BEATS   = 8,
  parameter bit EARLY_END   = 1'b1,
  parameter int ID_W        = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] lockIn,
  input  logic [1:0]             htrans,
  input  logic [2:0]             hburst,
  input  logic                   hready,
  input  logic [NUM_MASTERS-1:0] splitSet,
  input  logic [NUM_MASTERS-1:0] splitClear,
  output logic [NUM_MASTERS-1:0] grantOut,
  output logic [ID_W-1:0]        masterId,
  output logic                   masterLock
);

  arbStb_t                stb;
  logic [NUM_MASTERS-1:0] eligible, pendMask;
  logic                   reqNonDef;

  busarb_ctrl #(
    .NUM_MASTERS(NUM_MASTERS), .DEFAULT_ID(DEFAULT_ID), .MAX_BEATS(MAX_BEATS),
    .EARLY_END(EARLY_END), .ID_W(ID_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lockIn(lockIn), .htrans(htrans),
    .hburst(hburst), .hready(hready), .splitSet(splitSet), .splitClear(splitClear),
    .grantVec(grantOut), .ownerId(masterId), .stb(stb), .eligible(eligible),
    .reqNonDef(reqNonDef), .pendMask(pendMask)
  );

  busarb_path #(
    .NUM_MASTERS(NUM_MASTERS), .DEFAULT_ID(DEFAULT_ID), .PARK_ID(PARK_ID), .ID_W(ID_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .eligible(eligible), .reqNonDef(reqNonDef),
    .pendMask(pendMask), .lockIn(lockIn), .grantOut(grantOut), .masterId(masterId),
    .masterLock(masterLock)
  );

endmodule

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;

  localparam int N  = 4;
  localparam int NV = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqIn = '0, lockIn = '0, splitSet = '0, splitClear = '0;
  logic [1:0]   htrans = 2'b00;
  logic [2:0]   hburst = 3'b000;
  logic         hready = 1'b1;
  logic [N-1:0] grantOut;
  logic [3:0]   masterId;
  logic         masterLock;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bus_arbiter #(
    .NUM_MASTERS(N), .DEFAULT_ID(0), .PARK_ID(3), .MAX_BEATS(4), .EARLY_END(1'b1), .ID_W(4)
  ) i_bus_arbiter (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lockIn(lockIn), .htrans(htrans),
    .hburst(hburst), .hready(hready), .splitSet(splitSet), .splitClear(splitClear),
    .grantOut(grantOut), .masterId(masterId), .masterLock(masterLock)
  );

  localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;
  localparam logic [2:0] SGL = 3'b000, I4 = 3'b011, I8 = 3'b101;

  function automatic logic [31:0] V(input int tag, input logic [3:0] req, input logic [3:0] lck,
                                    input logic [1:0] tr, input logic [2:0] bu, input logic rdy,
                                    input logic [3:0] sset, input logic [3:0] sclr,
                                    input logic [3:0] expId, input logic expLock);
    return {1'b0, 4'(tag), req, lck, tr, bu, rdy, sset, sclr, expId, expLock};
  endfunction

  localparam logic [31:0] VEC [0:NV-1] = '{
    V(11, 4'b0000, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 3, 0), // 0  R11 park
    V( 3, 4'b0100, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 2, 0), // 1  R3
    V( 4, 4'b0110, 4'b0000, NSQ, I4,  1, 4'b0000, 4'b0000, 2, 0), // 2  R4 first beat
    V( 4, 4'b0110, 4'b0000, SQ,  I4,  1, 4'b0000, 4'b0000, 2, 0), // 3  R4
    V( 2, 4'b0110, 4'b0000, SQ,  I4,  0, 4'b0000, 4'b0000, 2, 0), // 4  R2 wait state
    V( 4, 4'b0110, 4'b0000, SQ,  I4,  1, 4'b0000, 4'b0000, 2, 0), // 5  R4
    V( 3, 4'b0110, 4'b0000, SQ,  I4,  1, 4'b0000, 4'b0000, 1, 0), // 6  R3 last beat
    V( 5, 4'b0110, 4'b0000, NSQ, I8,  1, 4'b0000, 4'b0000, 1, 0), // 7  R5 beat 1
    V( 4, 4'b0110, 4'b0000, BSY, I8,  1, 4'b0000, 4'b0000, 1, 0), // 8  R4 busy
    V( 5, 4'b0110, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 1, 0), // 9  R5 beat 2
    V( 5, 4'b0110, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 1, 0), // 10 R5 beat 3
    V( 5, 4'b0110, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 2, 0), // 11 R5 cut
    V( 6, 4'b0110, 4'b0100, NSQ, SGL, 1, 4'b0000, 4'b0000, 2, 1), // 12 R6
    V( 6, 4'b0110, 4'b0100, NSQ, SGL, 1, 4'b0000, 4'b0000, 2, 1), // 13 R6
    V( 7, 4'b0110, 4'b0000, NSQ, SGL, 1, 4'b0000, 4'b0000, 2, 0), // 14 R7 tail
    V( 3, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 1, 0), // 15 R3
    V( 9, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0010, 4'b0000, 1, 0), // 16 R9 mark 1
    V( 9, 4'b0110, 4'b0000, NSQ, I4,  1, 4'b0000, 4'b0000, 2, 0), // 17 R9 evict
    V( 9, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0100, 4'b0000, 2, 0), // 18 R9 mark 2
    V(10, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 0, 0), // 19 R10
    V(10, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0010, 0, 0), // 20 R10
    V( 9, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 1, 0), // 21 R9 released
    V(11, 4'b0000, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0100, 3, 0), // 22 R11
    V( 5, 4'b1000, 4'b0000, NSQ, I8,  1, 4'b0000, 4'b0000, 3, 0), // 23 R5
    V( 5, 4'b1000, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 3, 0), // 24 R5
    V( 5, 4'b1000, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 3, 0), // 25 R5
    V( 5, 4'b1000, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 3, 0), // 26 R5 no rival
    V( 5, 4'b1000, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 3, 0), // 27 R5 saturated
    V( 5, 4'b1010, 4'b0000, SQ,  I8,  1, 4'b0000, 4'b0000, 1, 0), // 28 R5 rival cuts
    V( 8, 4'b0010, 4'b0010, IDL, SGL, 1, 4'b0000, 4'b0000, 1, 1), // 29 R8
    V( 7, 4'b0110, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 1, 0), // 30 R7
    V( 3, 4'b0100, 4'b0000, IDL, SGL, 1, 4'b0000, 4'b0000, 2, 0)  // 31 R3
  };

  task automatic check(input int tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: state held in reset
    @(negedge clk);
    @(negedge clk);
    check(1, "reset id", int'(masterId), 0);
    check(1, "reset grant", int'(grantOut), 1);
    check(1, "reset lock", int'(masterLock), 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      int tag;
      v = VEC[k];
      tag = int'(v[30:27]);
      reqIn = v[26:23]; lockIn = v[22:19]; htrans = v[18:17]; hburst = v[16:14];
      hready = v[13]; splitSet = v[12:9]; splitClear = v[8:5];
      @(posedge clk);
      @(negedge clk);
      check(tag, $sformatf("row %0d id", k), int'(masterId), int'(v[4:1]));
      check(tag, $sformatf("row %0d lock", k), int'(masterLock), int'(v[0]));
      check(12, $sformatf("row %0d grant vector", k), int'(grantOut), 1 << v[4:1]);
    end

    // R2: ready low across a would-be hand-over keeps the lock flag too
    reqIn = 4'b0010; lockIn = 4'b0010; htrans = IDL; hburst = SGL; hready = 1'b0;
    splitSet = '0; splitClear = '0;
    @(posedge clk);
    @(negedge clk);
    check(2, "frozen id", int'(masterId), 2);
    check(2, "frozen lock", int'(masterLock), 0);
    hready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(8, "lock follows new owner", int'(masterLock), 1);
    check(3, "owner after release", int'(masterId), 1);

    // R1: reset mid-run returns to the default owner
    rstN = 1'b0;
    @(negedge clk);
    check(1, "rerun reset id", int'(masterId), 0);
    check(1, "rerun reset lock", int'(masterLock), 0);
    check(1, "rerun reset grant", int'(grantOut), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule